// File: doc/BRIEF.md
# Dual-Channel Switchable-Ratio Sinc Decimator

This block turns two single-bit sigma-delta modulator streams (left and right) into multi-bit two's complement samples with a third-order cascaded integrator-comb filter. All three integrators run at the modulator clock. A shared phase counter marks a decimation boundary once per output period, and at each boundary three comb stages with a differential delay of one take the result from the last integrator. The first-stage output rate is fixed at eight times the audio rate. The modulator clock is either 128 or 64 times the audio rate, so a select input picks a decimation ratio of 16 or 8 to match.

The ratio select is latched during reset. After reset it is sampled only at decimation boundaries. When it differs from the active ratio at a boundary, the sample in progress is still delivered at the old ratio. The comb delay lines are then cleared, and the strobe stays low for three boundaries while the combs refill. The integrators are sized for the larger ratio and wrap freely, which the comb differences tolerate.

Top module: `sinc_decim_dual`

## Requirements
- R1: While reset is high and in the first cycle after it, both sample outputs are 0 and the strobe is low. The ratio select value present during reset becomes the active ratio.
- R2: With an active ratio select of 0, strobes are exactly 16 clock cycles apart.
- R3: With an active ratio select of 1, strobes are exactly 8 clock cycles apart.
- R4: The strobe is high for a single clock cycle per sample and is shared by both channels. The sample outputs hold their value while the strobe is low.
- R5: A modulator bit of 1 counts as +1 and a bit of 0 counts as -1. In steady state, an all-ones input gives +N^3 and an all-zeros input gives -N^3 (N is the ratio: ±4096 at 16, ±512 at 8), as 14-bit two's complement.
- R6: In steady state (from the fifth strobe after reset), an input pattern whose period divides N gives N^2·(2k−N), where k is the number of ones in any N consecutive bits.
- R7: The two channels are filtered independently. Each output depends only on its own modulator input.
- R8: A change of ratio select in the middle of a frame does not shorten or lengthen that frame. The next strobe still comes one old-ratio period after the previous one and carries an old-ratio value.
- R9: The integrators wrap modulo 2^14, and outputs stay exact over runs far longer than the wrap period.
- R10: After a ratio change, the next strobe comes four new-ratio periods after the last old-ratio strobe. It already carries the correct steady-state value for the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 1 | Ratio select: 0 = divide by 16, 1 = divide by 8 |
| mod_l | input | 1 | Left modulator bit |
| mod_r | input | 1 | Right modulator bit |
| smp_l | output | 14 | Left decimated sample, two's complement |
| smp_r | output | 14 | Right decimated sample, two's complement |
| smp_valid | output | 1 | One-cycle strobe marking new samples on both channels |

## Verification
Constant all-ones and all-zeros inputs establish the signs, full-scale gain and input mapping at both ratios. Periodic patterns with different ones densities (alternating, one in four, fifteen in sixteen, pairs per byte) separate a correct N^2 weighting from an off-by-one window or a missing integrator stage. Different patterns on the two channels expose any crosstalk. A mid-frame ratio switch under constant input shows whether the frame in progress completes, whether the three-boundary refill is held back, and whether the first new-ratio value is already settled. Long constant runs carry the integrators through many wraps.

// File: rtl/sinc_decim_pkg.sv
package sinc_decim_pkg;

  // Width that holds an order-M filter at ratio 2^L on a signed +/-1 input.
  function automatic int cic_width(input int order, input int log2_ratio);
    return 2 + order * log2_ratio;
  endfunction

  // Magnitude of the steady-state response to a constant input.
  function automatic int cic_full_scale(input int order, input int log2_ratio);
    return 1 << (order * log2_ratio);
  endfunction

endpackage

// File: rtl/sinc_phase_ctrl.sv
module sinc_phase_ctrl #(
  parameter int ORDER     = 3,
  parameter int SLOW_LOG2 = 4,
  parameter int FAST_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ratio_sel,
  output logic tick,
  output logic flush,
  output logic emit
);
  localparam int CNT_W  = SLOW_LOG2;
  localparam int WARM_W = $clog2(ORDER + 1);
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'((1 << SLOW_LOG2) - 1);
  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'((1 << FAST_LOG2) - 1);

  logic [CNT_W-1:0]  ph;
  logic              rate_q;
  logic [WARM_W-1:0] warm;
  logic [CNT_W-1:0]  last;

  assign last  = rate_q ? LAST_FAST : LAST_SLOW;
  assign tick  = (ph == last);
  assign flush = tick && (ratio_sel != rate_q);
  assign emit  = tick && (warm == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      rate_q <= ratio_sel;
      warm   <= '0;
    end else begin
      ph <= tick ? '0 : ph + 1'b1;
      if (flush) begin
        rate_q <= ratio_sel;
        warm   <= WARM_W'(ORDER);
      end else if (tick && (warm != '0)) begin
        warm <= warm - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sinc_integ_chain.sv
module sinc_integ_chain #(
  parameter int ORDER = 3,
  parameter int DW    = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_in,
  output logic signed [DW-1:0] acc_out
);
  localparam logic signed [DW-1:0] PLUS1  = DW'(1);
  localparam logic signed [DW-1:0] MINUS1 = {DW{1'b1}};

  logic signed [DW-1:0] acc [ORDER];
  logic signed [DW-1:0] step;

  assign step = bit_in ? PLUS1 : MINUS1;

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) acc[k] <= '0;
        else     acc[k] <= acc[k] + step;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) acc[k] <= '0;
        else     acc[k] <= acc[k] + acc[k-1];
      end
    end
  end

  assign acc_out = acc[ORDER-1];
endmodule

// File: rtl/sinc_comb_chain.sv
module sinc_comb_chain #(
  parameter int ORDER = 3,
  parameter int DW    = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 flush,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);
  logic signed [DW-1:0] diff [ORDER+1];
  logic signed [DW-1:0] dly  [ORDER];

  always_comb begin
    diff[0] = din;
    for (int k = 0; k < ORDER; k++) begin
      diff[k+1] = diff[k] - dly[k];
    end
  end

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || (tick && flush)) dly[k] <= '0;
      else if (tick)              dly[k] <= diff[k];
    end
  end

  assign dout = diff[ORDER];
endmodule

// File: rtl/sinc_decim_dual.sv
module sinc_decim_dual #(
  parameter int ORDER     = 3,
  parameter int SLOW_LOG2 = 4,
  parameter int FAST_LOG2 = 3,
  localparam int DW = sinc_decim_pkg::cic_width(ORDER, SLOW_LOG2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ratio_sel,
  input  logic          mod_l,
  input  logic          mod_r,
  output logic [DW-1:0] smp_l,
  output logic [DW-1:0] smp_r,
  output logic          smp_valid
);
  localparam int NCH = 2;

  logic                 tick, flush, emit;
  logic [NCH-1:0]       mod_bits;
  logic signed [DW-1:0] integ [NCH];
  logic signed [DW-1:0] comb  [NCH];
  logic        [DW-1:0] smp_q [NCH];

  assign mod_bits = {mod_r, mod_l};

  sinc_phase_ctrl #(
    .ORDER(ORDER), .SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)
  ) u_phase (
    .clk(clk), .rst(rst), .ratio_sel(ratio_sel),
    .tick(tick), .flush(flush), .emit(emit)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    sinc_integ_chain #(.ORDER(ORDER), .DW(DW)) u_integ (
      .clk(clk), .rst(rst), .bit_in(mod_bits[ch]), .acc_out(integ[ch])
    );

    sinc_comb_chain #(.ORDER(ORDER), .DW(DW)) u_comb (
      .clk(clk), .rst(rst), .tick(tick), .flush(flush),
      .din(integ[ch]), .dout(comb[ch])
    );

    always_ff @(posedge clk) begin
      if (rst)       smp_q[ch] <= '0;
      else if (emit) smp_q[ch] <= comb[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) smp_valid <= 1'b0;
    else     smp_valid <= emit;
  end

  assign smp_l = smp_q[0];
  assign smp_r = smp_q[1];
endmodule

// File: rtl/sinc_decim_checker.sv
module sinc_decim_checker #(
  parameter int DW        = 14,
  parameter int FULL      = 4096,
  parameter int MIN_RATIO = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_valid,
  input logic [DW-1:0] smp_l,
  input logic [DW-1:0] smp_r
);
  logic       was_rst = 1'b0;
  logic       seen;
  int         gap;

  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (was_rst) begin
      p_reset_clear_r1: assert (!smp_valid && smp_l == '0 && smp_r == '0)
        else $error("reset state not clear");
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
      gap  <= 0;
    end else if (smp_valid) begin
      seen <= 1'b1;
      gap  <= 0;
    end else if (gap < 1000) begin
      gap <= gap + 1;
    end
  end

  p_gap_min_r2: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && seen) |-> (gap >= MIN_RATIO - 1))
    else $error("strobes too close");

  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid)
    else $error("strobe longer than one cycle");

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |-> ($stable(smp_l) && $stable(smp_r)))
    else $error("sample changed without strobe");

  p_bound_r5: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> ($signed(smp_l) <= FULL && $signed(smp_l) >= -FULL &&
                   $signed(smp_r) <= FULL && $signed(smp_r) >= -FULL))
    else $error("sample beyond full scale");
endmodule

bind sinc_decim_dual sinc_decim_checker #(
  .DW(DW),
  .FULL(sinc_decim_pkg::cic_full_scale(ORDER, SLOW_LOG2)),
  .MIN_RATIO(1 << FAST_LOG2)
) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_l(smp_l), .smp_r(smp_r)
);

// File: tb/tb_sinc_decim_dual.sv
module tb_sinc_decim_dual;
  localparam int DW = 14;
  localparam int NV = 7;
  // {ratio_sel, left pattern, right pattern}; patterns repeat every 16 bits
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'hFFFF, 16'h0000},
    {1'b0, 16'hAAAA, 16'hEEEE},
    {1'b0, 16'h8888, 16'h0001},
    {1'b1, 16'hFFFF, 16'h0000},
    {1'b1, 16'h7F7F, 16'h1111},
    {1'b0, 16'hFFFE, 16'h5555},
    {1'b1, 16'h0303, 16'hCCCC}
  };

  logic clk = 1'b0;
  logic rst, ratio_sel, mod_l, mod_r;
  logic [DW-1:0] smp_l, smp_r;
  logic smp_valid;
  logic [15:0] pl = '0, pr = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sinc_decim_dual dut (
    .clk(clk), .rst(rst), .ratio_sel(ratio_sel), .mod_l(mod_l), .mod_r(mod_r),
    .smp_l(smp_l), .smp_r(smp_r), .smp_valid(smp_valid)
  );

  initial begin
    int idx = 0;
    mod_l = 1'b0;
    mod_r = 1'b0;
    forever begin
      @(negedge clk);
      mod_l = pl[idx];
      mod_r = pr[idx];
      idx = (idx + 1) % 16;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int steady(input logic [15:0] pat, input logic fast);
    int n = fast ? 8 : 16;
    int k = 0;
    for (int b = 0; b < n; b++) k += int'(pat[b]);
    return n * n * (2 * k - n);
  endfunction

  task automatic wait_valid(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!smp_valid && gap < 200);
    if (!smp_valid) check("strobe timeout", 0, 1);
  endtask

  task automatic do_reset(input logic r);
    rst = 1'b1;
    ratio_sel = r;
    repeat (3) @(negedge clk);
    check("R1 valid", int'(smp_valid), 0);
    check("R1 left", int'(smp_l), 0);
    check("R1 right", int'(smp_r), 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int gap;
    rst = 1'b1;
    ratio_sel = 1'b0;
    // Table walk: R5 R6 R7 R9 values, R2 R3 spacing, R1 reset each time
    for (int v = 0; v < NV; v++) begin
      logic fast;
      fast = VEC[v][32];
      pl = VEC[v][31:16];
      pr = VEC[v][15:0];
      do_reset(fast);
      for (int s = 0; s < 4; s++) wait_valid(gap);
      for (int s = 0; s < 20; s++) begin
        wait_valid(gap);
        check(fast ? "R3 spacing" : "R2 spacing", gap, fast ? 8 : 16);
        check("R6 R9 left", int'($signed(smp_l)), steady(pl, fast));
        check("R7 R5 right", int'($signed(smp_r)), steady(pr, fast));
      end
    end

    // R4: strobe lasts one cycle, outputs hold afterwards
    pl = 16'hFFFF;
    pr = 16'h0000;
    do_reset(1'b0);
    for (int s = 0; s < 6; s++) wait_valid(gap);
    @(negedge clk);
    check("R4 strobe low", int'(smp_valid), 0);
    check("R4 left hold", int'($signed(smp_l)), 4096);
    check("R4 right hold", int'($signed(smp_r)), -4096);

    // R8 and R10: switch from 16 to 8 in mid-frame
    wait_valid(gap);
    repeat (3) @(negedge clk);
    ratio_sel = 1'b1;
    wait_valid(gap);
    check("R8 old frame length", gap + 3, 16);
    check("R8 old value", int'($signed(smp_l)), 4096);
    wait_valid(gap);
    check("R10 refill gap", gap, 32);
    check("R10 new left", int'($signed(smp_l)), 512);
    check("R10 new right", int'($signed(smp_r)), -512);
    wait_valid(gap);
    check("R3 after switch", gap, 8);

    // R8 and R10: switch back from 8 to 16
    repeat (2) @(negedge clk);
    ratio_sel = 1'b0;
    wait_valid(gap);
    check("R8 old frame length back", gap + 2, 8);
    check("R8 old value back", int'($signed(smp_l)), 512);
    wait_valid(gap);
    check("R10 refill gap back", gap, 64);
    check("R10 new left back", int'($signed(smp_l)), 4096);
    wait_valid(gap);
    check("R2 after switch", gap, 16);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule